// File: doc/BRIEF.md
# Packetized DRAM Transaction Request Sequencer

This block sits on the controller side of a packetized DRAM link that has eight banks. It runs exactly one memory transaction at a time. A command gives the direction (read or write), a bank, a row and one or two column addresses. The sequencer then places an activate, the column requests and a closing precharge on a request bus. Each request goes out in the clock cycle that the link's timing rules fix relative to the activate.

For writes the block drives each 64-bit data packet as two 32-bit halves over two consecutive cycles. For reads it collects the returned halves into two 64-bit result registers. All spacings are whole-cycle parameters, so a different speed grade only needs new parameter values. A `busy` flag covers the transaction, and a single-cycle `done` pulse closes it.

Top module: `dram_txn_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `busy`, `done`, `rq_valid` and `dq_out_en` are low, and `rq_word`, `dq_out`, `rd_data0` and `rd_data1` are zero. Taking `rst` high in the middle of a transaction clears these outputs by the next cycle.
- R2: A command is accepted when `cmd_valid` is high at a clock edge while `busy` is low. In the next cycle (cycle 0), `rq_valid` is high and an activate word carries the command's bank and row. `busy` is high from cycle 0 until the `done` cycle.
- R3: The first column request appears in cycle T_RCD (default 5). Its opcode is RD for a read and WR for a write, and it carries the bank and the first column.
- R4: When `cmd_two` is set, a second column request carrying the second column appears T_CC cycles (default 2) after the first. Otherwise no second request is issued.
- R5: For a write, each column's data packet is driven on `dq_out` with `dq_out_en` high. Bits [31:0] are driven T_CWD cycles (default 5) after that column request, and bits [63:32] one cycle later. In every other cycle `dq_out_en` is low and `dq_out` is zero.
- R6: For a read, the value on `dq_in` T_CAC cycles (default 6) after a column request is stored as bits [31:0] of that column's result. The value one cycle later is stored as bits [63:32]. Column one's result goes to `rd_data0` and column two's result goes to `rd_data1`.
- R7: The precharge request, carrying the bank and a zero address, appears T_WRP cycles (default 7) after the last write request. For a read it appears T_RDP cycles (default 5) after the last read request.
- R8: `done` is high for exactly one cycle. That cycle comes one cycle after the later of two events: the precharge, and the last data half (driven for a write, captured for a read). With the defaults this is cycle 13 for one column and cycle 15 for two. In the `done` cycle `busy` is low.
- R9: A `cmd_valid` seen while `busy` is high is ignored. The running transaction keeps its bank, row and columns, and no further activate follows it.
- R10: The request word layout is as follows. Bits [23:21] hold the opcode: NOP=0, ACT=1, RD=2, WR=3, PRE=4. Bits [20:18] hold the bank. Bits [17:0] hold the row or column, zero-extended. Whenever `rq_valid` is low, the whole word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_two | input | 1 | 1 = two column accesses |
| cmd_bank | input | 3 | Bank number |
| cmd_row | input | ROW_W | Row address |
| cmd_col0 | input | COL_W | First column address |
| cmd_col1 | input | COL_W | Second column address |
| wr_data0 | input | DATA_W | Write packet for the first column |
| wr_data1 | input | DATA_W | Write packet for the second column |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rq_valid | output | 1 | Request word valid this cycle |
| rq_word | output | 24 | Request word |
| dq_out | output | DATA_W/2 | Write data half |
| dq_out_en | output | 1 | Write data driven this cycle |
| dq_in | input | DATA_W/2 | Returned read data half |
| rd_data0 | output | DATA_W | Read result, first column |
| rd_data1 | output | DATA_W | Read result, second column |

## Verification
Several properties are checked on every cycle: the request word is zero whenever it is not valid, and requests and write data appear only while busy. They also cover `done` (a lone pulse that never overlaps `busy`), the activate that must open every busy period, and the rule that no activate follows a command offered while busy. What no cycle-local property can show is left to the bench's scenarios: the exact issue cycle of each column request and of the precharge, which write half lands in which cycle, and which read half ends up in which result register. The bench also drives a stream of commands during a transaction and resets the block in mid-transaction.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  localparam int NUM_BANKS = 8;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int ADDR_W    = 18;
  localparam int RQ_W      = 3 + BANK_W + ADDR_W;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4
  } rq_op_e;

  function automatic logic [RQ_W-1:0] rq_pack(input rq_op_e op,
                                              input logic [BANK_W-1:0] bank,
                                              input logic [ADDR_W-1:0] addr);
    return {op, bank, addr};
  endfunction
endpackage

// File: rtl/seq_schedule.sv
module seq_schedule #(
  parameter int T_RCD = 5,
  parameter int T_CC  = 2,
  parameter int T_CWD = 5,
  parameter int T_CAC = 6,
  parameter int T_WRP = 7,
  parameter int T_RDP = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_wr,
  input  logic             two,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] cnt,
  output logic [1:0]       col_go,
  output logic             pre_go
);
  localparam int COL0_AT = T_RCD;
  localparam int COL1_AT = T_RCD + T_CC;

  logic [CNT_W-1:0] nxt, last_at, pre_at, data_end, end_at;

  always_comb begin
    nxt      = cnt + 1'b1;
    last_at  = two ? CNT_W'(COL1_AT) : CNT_W'(COL0_AT);
    pre_at   = last_at + (is_wr ? CNT_W'(T_WRP) : CNT_W'(T_RDP));
    data_end = last_at + (is_wr ? CNT_W'(T_CWD + 1) : CNT_W'(T_CAC + 1));
    end_at   = ((pre_at > data_end) ? pre_at : data_end) + 1'b1;
    pre_go   = busy && (nxt == pre_at);
  end

  assign col_go[0] = busy && (nxt == CNT_W'(COL0_AT));
  assign col_go[1] = busy && two && (nxt == CNT_W'(COL1_AT));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= nxt;
        if (nxt == end_at) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rq_issue.sv
module rq_issue
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [BANK_W-1:0]     new_bank,
  input  logic [ROW_W-1:0]      new_row,
  input  logic [BANK_W-1:0]     bank,
  input  logic [1:0][COL_W-1:0] cols,
  input  logic                  is_wr,
  input  logic [1:0]            col_go,
  input  logic                  pre_go,
  output logic                  rq_valid,
  output logic [RQ_W-1:0]       rq_word
);
  logic [RQ_W-1:0] word_d;
  rq_op_e          col_op;

  always_comb begin
    col_op = is_wr ? OP_WR : OP_RD;
    if (start)          word_d = rq_pack(OP_ACT, new_bank, ADDR_W'(new_row));
    else if (col_go[0]) word_d = rq_pack(col_op, bank, ADDR_W'(cols[0]));
    else if (col_go[1]) word_d = rq_pack(col_op, bank, ADDR_W'(cols[1]));
    else if (pre_go)    word_d = rq_pack(OP_PRE, bank, '0);
    else                word_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rq_valid <= 1'b0;
      rq_word  <= '0;
    end else begin
      rq_valid <= start || (|col_go) || pre_go;
      rq_word  <= word_d;
    end
  end
endmodule

// File: rtl/wdata_drive.sv
module wdata_drive #(
  parameter int T_RCD  = 5,
  parameter int T_CC   = 2,
  parameter int T_CWD  = 5,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   busy,
  input  logic                   is_wr,
  input  logic                   two,
  input  logic [CNT_W-1:0]       cnt,
  input  logic [1:0][DATA_W-1:0] wdata,
  output logic [DATA_W/2-1:0]    dq_out,
  output logic                   dq_out_en
);
  localparam int HALF_W = DATA_W / 2;

  logic [CNT_W-1:0]  nxt;
  logic [1:0]        lo_hit, hi_hit;
  logic [HALF_W-1:0] dq_d;

  assign nxt = cnt + 1'b1;

  for (genvar k = 0; k < 2; k++) begin : g_slot
    localparam int LO_AT = T_RCD + k * T_CC + T_CWD;
    logic used;
    assign used      = busy && is_wr && ((k == 0) || two);
    assign lo_hit[k] = used && (nxt == CNT_W'(LO_AT));
    assign hi_hit[k] = used && (nxt == CNT_W'(LO_AT + 1));
  end

  always_comb begin
    dq_d = '0;
    for (int k = 0; k < 2; k++) begin
      if (lo_hit[k]) dq_d = wdata[k][HALF_W-1:0];
      if (hi_hit[k]) dq_d = wdata[k][DATA_W-1:HALF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out    <= '0;
      dq_out_en <= 1'b0;
    end else begin
      dq_out    <= dq_d;
      dq_out_en <= |{lo_hit, hi_hit};
    end
  end
endmodule

// File: rtl/rdata_capture.sv
module rdata_capture #(
  parameter int T_RCD  = 5,
  parameter int T_CC   = 2,
  parameter int T_CAC  = 6,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   busy,
  input  logic                   is_wr,
  input  logic                   two,
  input  logic [CNT_W-1:0]       cnt,
  input  logic [DATA_W/2-1:0]    dq_in,
  output logic [1:0][DATA_W-1:0] rd_data
);
  localparam int HALF_W = DATA_W / 2;

  for (genvar k = 0; k < 2; k++) begin : g_slot
    localparam int LO_AT = T_RCD + k * T_CC + T_CAC;
    logic used;
    assign used = busy && !is_wr && ((k == 0) || two);

    always_ff @(posedge clk) begin
      if (rst) begin
        rd_data[k] <= '0;
      end else if (used && (cnt == CNT_W'(LO_AT))) begin
        rd_data[k][HALF_W-1:0] <= dq_in;
      end else if (used && (cnt == CNT_W'(LO_AT + 1))) begin
        rd_data[k][DATA_W-1:HALF_W] <= dq_in;
      end
    end
  end
endmodule

// File: rtl/dram_txn_seq.sv
module dram_txn_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int DATA_W = 64,
  parameter int T_RCD  = 5,
  parameter int T_CC   = 2,
  parameter int T_CWD  = 5,
  parameter int T_CAC  = 6,
  parameter int T_WRP  = 7,
  parameter int T_RDP  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic                cmd_write,
  input  logic                cmd_two,
  input  logic [BANK_W-1:0]   cmd_bank,
  input  logic [ROW_W-1:0]    cmd_row,
  input  logic [COL_W-1:0]    cmd_col0,
  input  logic [COL_W-1:0]    cmd_col1,
  input  logic [DATA_W-1:0]   wr_data0,
  input  logic [DATA_W-1:0]   wr_data1,
  output logic                busy,
  output logic                done,
  output logic                rq_valid,
  output logic [RQ_W-1:0]     rq_word,
  output logic [DATA_W/2-1:0] dq_out,
  output logic                dq_out_en,
  input  logic [DATA_W/2-1:0] dq_in,
  output logic [DATA_W-1:0]   rd_data0,
  output logic [DATA_W-1:0]   rd_data1
);
  localparam int SPAN  = T_RCD + T_CC + T_WRP + T_RDP + T_CWD + T_CAC + 4;
  localparam int CNT_W = $clog2(SPAN) + 1;

  logic                   start, is_wr, two, pre_go;
  logic [BANK_W-1:0]      bank;
  logic [1:0][COL_W-1:0]  cols;
  logic [1:0][DATA_W-1:0] wdata, rd_data;
  logic [CNT_W-1:0]       cnt;
  logic [1:0]             col_go;

  assign start    = cmd_valid && !busy;
  assign rd_data0 = rd_data[0];
  assign rd_data1 = rd_data[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      is_wr <= 1'b0;
      two   <= 1'b0;
      bank  <= '0;
      cols  <= '0;
      wdata <= '0;
    end else if (start) begin
      is_wr <= cmd_write;
      two   <= cmd_two;
      bank  <= cmd_bank;
      cols  <= {cmd_col1, cmd_col0};
      wdata <= {wr_data1, wr_data0};
    end
  end

  seq_schedule #(
    .T_RCD(T_RCD), .T_CC(T_CC), .T_CWD(T_CWD), .T_CAC(T_CAC),
    .T_WRP(T_WRP), .T_RDP(T_RDP), .CNT_W(CNT_W)
  ) u_sched (
    .clk(clk), .rst(rst), .start(start), .is_wr(is_wr), .two(two),
    .busy(busy), .done(done), .cnt(cnt), .col_go(col_go), .pre_go(pre_go)
  );

  rq_issue #(.ROW_W(ROW_W), .COL_W(COL_W)) u_rq (
    .clk(clk), .rst(rst), .start(start), .new_bank(cmd_bank),
    .new_row(cmd_row), .bank(bank), .cols(cols), .is_wr(is_wr),
    .col_go(col_go), .pre_go(pre_go), .rq_valid(rq_valid), .rq_word(rq_word)
  );

  wdata_drive #(
    .T_RCD(T_RCD), .T_CC(T_CC), .T_CWD(T_CWD), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_wr (
    .clk(clk), .rst(rst), .busy(busy), .is_wr(is_wr), .two(two), .cnt(cnt),
    .wdata(wdata), .dq_out(dq_out), .dq_out_en(dq_out_en)
  );

  rdata_capture #(
    .T_RCD(T_RCD), .T_CC(T_CC), .T_CAC(T_CAC), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_rd (
    .clk(clk), .rst(rst), .busy(busy), .is_wr(is_wr), .two(two), .cnt(cnt),
    .dq_in(dq_in), .rd_data(rd_data)
  );
endmodule

// File: rtl/dram_txn_seq_checker.sv
module dram_txn_seq_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              busy,
  input logic              done,
  input logic              rq_valid,
  input logic [23:0]       rq_word,
  input logic [DATA_W/2-1:0] dq_out,
  input logic              dq_out_en
);
  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_rq_only_busy_R2: assert property (@(posedge clk) disable iff (rst)
    rq_valid |-> busy);
  assert_act_opens_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (rq_valid && rq_word[23:21] == 3'd1));
  assert_idle_word_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !rq_valid |-> (rq_word == 24'd0));
  assert_no_act_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> !(rq_valid && rq_word[23:21] == 3'd1));
  assert_dq_only_busy_R5: assert property (@(posedge clk) disable iff (rst)
    dq_out_en |-> busy);
  assert_dq_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !dq_out_en |-> (dq_out == '0));
endmodule

bind dram_txn_seq dram_txn_seq_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .rq_valid(rq_valid), .rq_word(rq_word), .dq_out(dq_out), .dq_out_en(dq_out_en)
);

// File: tb/dram_txn_seq_test.sv
module dram_txn_seq_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic        two;
    logic [2:0]  bank;
    logic [11:0] row;
    logic [7:0]  c0;
    logic [7:0]  c1;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 3'd2, 12'h0A5, 8'h11, 8'h00},
    '{1'b1, 1'b1, 3'd7, 12'hFFF, 8'h3C, 8'hC3},
    '{1'b0, 1'b0, 3'd0, 12'h123, 8'hFF, 8'h00},
    '{1'b0, 1'b1, 3'd5, 12'h800, 8'h01, 8'h80}
  };

  logic        clk = 1'b0, rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_two = 1'b0;
  logic [2:0]  cmd_bank = '0;
  logic [11:0] cmd_row = '0;
  logic [7:0]  cmd_col0 = '0, cmd_col1 = '0;
  logic [63:0] wr_data0 = '0, wr_data1 = '0;
  logic [31:0] dq_in = '0;
  logic        busy, done, rq_valid, dq_out_en;
  logic [23:0] rq_word;
  logic [31:0] dq_out;
  logic [63:0] rd_data0, rd_data1;

  int tests = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_txn_seq uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_two(cmd_two), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col0(cmd_col0), .cmd_col1(cmd_col1), .wr_data0(wr_data0),
    .wr_data1(wr_data1), .busy(busy), .done(done), .rq_valid(rq_valid),
    .rq_word(rq_word), .dq_out(dq_out), .dq_out_en(dq_out_en), .dq_in(dq_in),
    .rd_data0(rd_data0), .rd_data1(rd_data1)
  );

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] wpat(input vec_t v, input int k);
    return {8{5'b0, v.bank}} ^ (k == 0 ? 64'hC3C3_0F0F_5A5A_FFFF : 64'h1234_5678_9ABC_DEF0);
  endfunction

  function automatic logic [63:0] rpat(input vec_t v, input int k);
    return {24'hBEEF00, v.c0, 24'hF00D00, v.c1} ^ (k == 0 ? 64'h0 : 64'hFFFF_0000_FFFF_0000);
  endfunction

  // hold: keep cmd_valid high (with changing fields) throughout the run (R9)
  task automatic run_txn(input vec_t v, input bit hold);
    int last, pre, fin, col1;
    logic [23:0] er;
    logic [31:0] ed;
    logic        ee;
    string       tag;
    col1 = v.two ? 7 : -100;
    last = v.two ? 7 : 5;
    pre  = last + (v.wr ? 7 : 5);
    fin  = ((pre > last + (v.wr ? 6 : 7)) ? pre : last + (v.wr ? 6 : 7)) + 1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = v.wr; cmd_two = v.two; cmd_bank = v.bank;
    cmd_row = v.row; cmd_col0 = v.c0; cmd_col1 = v.c1;
    wr_data0 = wpat(v, 0); wr_data1 = wpat(v, 1);
    @(posedge clk);
    for (int k = 0; k <= fin + 1; k++) begin
      @(negedge clk);
      if (hold && k < fin) begin
        cmd_bank = ~v.bank; cmd_row = ~v.row; cmd_col0 = ~v.c0; cmd_write = ~v.wr;
        wr_data0 = ~wr_data0;
      end else begin
        cmd_valid = 1'b0;
      end
      // read data returned on the link (R6); garbage elsewhere must not land
      if (!v.wr && k == 11) dq_in = rpat(v, 0)[31:0];
      else if (!v.wr && k == 12) dq_in = rpat(v, 0)[63:32];
      else if (!v.wr && k == col1 + 6) dq_in = rpat(v, 1)[31:0];
      else if (!v.wr && k == col1 + 7) dq_in = rpat(v, 1)[63:32];
      else dq_in = 32'hDEAD_0000 | 32'(k);
      // expected request word
      er = '0; tag = "R10";
      if (k == 0) begin er = {3'd1, v.bank, 6'd0, v.row}; tag = "R2"; end
      else if (k == 5) begin er = {v.wr ? 3'd3 : 3'd2, v.bank, 10'd0, v.c0}; tag = "R3"; end
      else if (k == col1) begin er = {v.wr ? 3'd3 : 3'd2, v.bank, 10'd0, v.c1}; tag = "R4"; end
      else if (k == pre) begin er = {3'd4, v.bank, 18'd0}; tag = "R7"; end
      if (hold && k > 0) tag = {tag, "/R9"};
      chk(rq_valid == (er != 0) && rq_word == er, tag, {39'd0, rq_valid, rq_word}, {39'd0, er != 0, er});
      // expected write data
      ee = 1'b1; ed = '0;
      if (v.wr && k == 10) ed = wpat(v, 0)[31:0];
      else if (v.wr && k == 11) ed = wpat(v, 0)[63:32];
      else if (v.wr && k == col1 + 5) ed = wpat(v, 1)[31:0];
      else if (v.wr && k == col1 + 6) ed = wpat(v, 1)[63:32];
      else ee = 1'b0;
      chk(dq_out_en == ee && dq_out == ed, "R5", {31'd0, dq_out_en, dq_out}, {31'd0, ee, ed});
      chk(busy == (k < fin) && done == (k == fin), "R8",
          {62'd0, busy, done}, {62'd0, k < fin, k == fin});
    end
    if (!v.wr) begin
      chk(rd_data0 == rpat(v, 0), "R6", rd_data0, rpat(v, 0));
      if (v.two) chk(rd_data1 == rpat(v, 1), "R6", rd_data1, rpat(v, 1));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !rq_valid && !dq_out_en && rq_word == 0 && dq_out == 0,
        "R1", {60'd0, busy, done, rq_valid, dq_out_en}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !rq_valid && rd_data0 == 0 && rd_data1 == 0,
        "R1", rd_data0 | rd_data1 | {61'd0, busy, done, rq_valid}, 64'd0);

    for (int i = 0; i < NV; i++) run_txn(VECS[i], 1'b0);

    // R9: commands offered throughout a transaction are ignored
    run_txn('{1'b1, 1'b1, 3'd3, 12'h5A5, 8'h44, 8'h55}, 1'b1);
    run_txn('{1'b0, 1'b1, 3'd6, 12'h00F, 8'h0F, 8'hF0}, 1'b1);
    repeat (2) begin
      @(negedge clk);
      chk(!rq_valid && !busy, "R9", {62'd0, rq_valid, busy}, 64'd0);
    end

    // R1: reset in the middle of a write
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_two = 1'b1; cmd_bank = 3'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (9) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !rq_valid && !dq_out_en && dq_out == 0 && rq_word == 0,
        "R1", {60'd0, busy, done, rq_valid, dq_out_en}, 64'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !rq_valid && !dq_out_en, "R1", {61'd0, busy, rq_valid, dq_out_en}, 64'd0);

    summary();
  end
endmodule